// File: doc/BRIEF.md
# I2C Address Phase Status Flags

This block keeps the three status flags that an I2C controller needs during and after the address phase. It works in both the master and the slave role. The block does not touch the bus wires. It watches events that other logic has already decoded:

- a start or stop seen on the bus,
- a start generated by this controller,
- single-cycle strobes for SCL rising and falling edges,
- the first byte after a start, as shifted in (or shifted out, when master).

From these it flags three things: that an extension code was seen, that the address matched the local one, and that this side owns the data direction (transmit). A fourth output enables the SDA driver. It follows the transmit flag, but only from the falling edge of the ninth clock of the first byte onward.

An internal 4-bit edge counter restarts at every detected start. It counts SCL rising edges only while the first byte is in flight. From this count it derives two strobes: one for the eighth rising edge, and one for the falling edge of the ninth clock. Flags are latched only on the eighth-edge strobe. Every clearing event wins over a set in the same cycle. Software-side controls come in as plain level inputs:

- an enable,
- an exit-from-communication request,
- a wait-cancel request,
- an arbitration-lost indication.

Top module: `i2c_addr_status`

## Requirements
- R1: On the eighth SCL rising edge of the first byte after a start, the extension flag sets when the byte's upper nibble `first_byte[7:4]` is 4'b0000 or 4'b1111. The byte is received MSB first, and the flag is visible in the cycle after that edge strobe.
- R2: On that same eighth edge, the match flag sets when `first_byte[7:1]` equals `own_addr`. Otherwise it stays 0.
- R3: The extension and match flags clear on start detect, stop detect, exit request, or `enable` falling from 1 to 0. Both are 0 while `enable` is 0.
- R4: The transmit flag clears on stop detect, exit request, `enable` falling, wait-cancel, or arbitration loss.
- R5: In the slave role (`is_master`=0), the transmit flag is 0 whenever both the extension flag and the match flag are 0.
- R6: In the master role, the transmit flag clears on `start_gen`. On the eighth edge it takes the inverse of the direction bit `first_byte[0]` (0 = master writes, giving transmit flag 1).
- R7: In the slave role, the transmit flag clears on start detect. On the eighth edge it takes the value of `first_byte[0]` (1 = master reads, giving transmit flag 1).
- R8: `sda_oe` is 0 whenever the transmit flag is 0. With the transmit flag at 1, `sda_oe` rises only after the falling edge of the first byte's ninth clock, not before.
- R9: A clearing event that lands in the same cycle as the eighth-edge strobe wins, and the flag stays 0.
- R10: SCL edges after the first byte's ninth clock leave every flag unchanged.
- R11: After reset, all flags and `sda_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Operation enable; a 1-to-0 change clears all flags |
| is_master | input | 1 | Role select: 1 = master rules, 0 = slave rules |
| start_det | input | 1 | Start condition detected on the bus (one cycle) |
| stop_det | input | 1 | Stop condition detected on the bus (one cycle) |
| start_gen | input | 1 | This controller generated a start (one cycle) |
| scl_rise | input | 1 | SCL rising edge strobe (one cycle) |
| scl_fall | input | 1 | SCL falling edge strobe (one cycle) |
| first_byte | input | 8 | Address byte shifted in or out, LSB is the direction bit |
| own_addr | input | 7 | Local slave address |
| exit_req | input | 1 | Exit-from-communication request |
| wait_cancel | input | 1 | Wait-cancel request |
| arb_lost | input | 1 | Arbitration lost |
| ext_flag | output | 1 | Extension code received |
| match_flag | output | 1 | Address matched |
| xmit_flag | output | 1 | Transmit direction owned by this side |
| sda_oe | output | 1 | SDA data driver enable |

## Verification
A counter that is off by one latches the flags from a seven-bit or nine-bit sample. It also moves the `sda_oe` rise by a whole SCL bit. Both errors show at the ports one cycle after the wrong strobe. A broken clear path leaves a flag at 1 in the cycle after a stop, exit, start or wait-cancel. A missing slave idle rule shows as the transmit flag rising for a non-matching read address, in the cycle after the eighth edge. A lost priority shows as a flag set in spite of a clearing event that arrived together with the eighth edge.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;

  // Upper nibble 0000 or 1111 marks a reserved (extension) address
  function automatic logic is_ext_code(input logic [3:0] nib);
    return (nib == 4'h0) || (nib == 4'hF);
  endfunction

  // Direction bit to transmit ownership: master owns on write (0), slave on read (1)
  function automatic logic xmit_from_dir(input logic master, input logic dir);
    return master ? ~dir : dir;
  endfunction

endpackage

// File: rtl/first_byte_counter.sv
module first_byte_counter #(
  parameter int CNT_W    = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic last_rise,
  output logic ack_fall
);
  localparam logic [CNT_W-1:0] LAST_M1 = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!enable || stop_det) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_det) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (scl_rise && cnt_q != ACK_CNT) cnt_q <= cnt_q + 1'b1;
      if (scl_fall && cnt_q == ACK_CNT) active_q <= 1'b0;
    end
  end

  assign last_rise = active_q && scl_rise && (cnt_q == LAST_M1);
  assign ack_fall  = active_q && scl_fall && (cnt_q == ACK_CNT);
endmodule

// File: rtl/status_flags.sv
module status_flags
  import i2c_as_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic is_master,
  input  logic start_det,
  input  logic stop_det,
  input  logic start_gen,
  input  logic exit_req,
  input  logic wait_cancel,
  input  logic arb_lost,
  input  logic last_rise,
  input  logic ack_fall,
  input  logic ext_hit,
  input  logic addr_hit,
  input  logic dir_bit,
  output logic addr_clr,
  output logic xmit_clr,
  output logic ext_flag,
  output logic match_flag,
  output logic xmit_flag,
  output logic drive_ok
);
  logic en_q, ext_q, match_q, xmit_q, drive_q;
  logic en_fall, ext_nxt, match_nxt, xmit_nxt, idle_nxt, role_clr, drive_clr;

  assign en_fall  = en_q && !enable;
  assign addr_clr = start_det || stop_det || exit_req || en_fall || !enable;

  always_comb begin
    ext_nxt   = ext_q;
    match_nxt = match_q;
    if (addr_clr) begin
      ext_nxt   = 1'b0;
      match_nxt = 1'b0;
    end else if (last_rise) begin
      if (ext_hit)  ext_nxt   = 1'b1;
      if (addr_hit) match_nxt = 1'b1;
    end
  end

  assign idle_nxt = !is_master && !ext_nxt && !match_nxt;
  assign role_clr = is_master ? start_gen : start_det;
  assign xmit_clr = stop_det || exit_req || en_fall || !enable || wait_cancel ||
                    arb_lost || role_clr || idle_nxt;

  always_comb begin
    xmit_nxt = xmit_q;
    if (xmit_clr)       xmit_nxt = 1'b0;
    else if (last_rise) xmit_nxt = xmit_from_dir(is_master, dir_bit);
  end

  assign drive_clr = start_det || start_gen || stop_det || !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ext_q   <= 1'b0;
      match_q <= 1'b0;
      xmit_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      en_q    <= enable;
      ext_q   <= ext_nxt;
      match_q <= match_nxt;
      xmit_q  <= xmit_nxt;
      if (drive_clr)     drive_q <= 1'b0;
      else if (ack_fall) drive_q <= 1'b1;
    end
  end

  assign ext_flag   = ext_q;
  assign match_flag = match_q;
  assign xmit_flag  = xmit_q;
  assign drive_ok   = drive_q;
endmodule

// File: rtl/i2c_addr_status.sv
module i2c_addr_status
  import i2c_as_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              is_master,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              start_gen,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [ADDR_W:0]   first_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              exit_req,
  input  logic              wait_cancel,
  input  logic              arb_lost,
  output logic              ext_flag,
  output logic              match_flag,
  output logic              xmit_flag,
  output logic              sda_oe
);
  localparam int BYTE_BITS = ADDR_W + 1;

  logic last_rise, ack_fall, ext_hit, addr_hit, addr_clr, xmit_clr, drive_ok;

  assign ext_hit  = is_ext_code(first_byte[ADDR_W -: 4]);
  assign addr_hit = (first_byte[ADDR_W:1] == own_addr);

  first_byte_counter #(.CNT_W(CNT_W), .BYTE_BITS(BYTE_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .last_rise(last_rise), .ack_fall(ack_fall)
  );

  status_flags u_flags (
    .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
    .start_det(start_det), .stop_det(stop_det), .start_gen(start_gen),
    .exit_req(exit_req), .wait_cancel(wait_cancel), .arb_lost(arb_lost),
    .last_rise(last_rise), .ack_fall(ack_fall),
    .ext_hit(ext_hit), .addr_hit(addr_hit), .dir_bit(first_byte[0]),
    .addr_clr(addr_clr), .xmit_clr(xmit_clr),
    .ext_flag(ext_flag), .match_flag(match_flag), .xmit_flag(xmit_flag),
    .drive_ok(drive_ok)
  );

  assign sda_oe = xmit_flag && drive_ok;
endmodule

// File: rtl/i2c_addr_status_chk.sv
module i2c_addr_status_chk
  import i2c_as_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       is_master,
  input logic       stop_det,
  input logic       wait_cancel,
  input logic       last_rise,
  input logic       addr_clr,
  input logic [7:0] first_byte,
  input logic       ext_flag,
  input logic       match_flag,
  input logic       xmit_flag,
  input logic       sda_oe
);
  // R1
  ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_rise && !addr_clr && is_ext_code(first_byte[7:4]) |=> ext_flag);

  // R3
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !ext_flag && !match_flag && !xmit_flag);

  // R4
  wait_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cancel |=> !xmit_flag);

  // R5
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master && $stable(is_master) && !ext_flag && !match_flag |-> !xmit_flag);

  // R8
  oe_needs_xmit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> xmit_flag);

  // R10
  match_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(last_rise));
endmodule

bind i2c_addr_status i2c_addr_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .stop_det(stop_det),
  .wait_cancel(wait_cancel), .last_rise(last_rise), .addr_clr(addr_clr),
  .first_byte(first_byte), .ext_flag(ext_flag), .match_flag(match_flag),
  .xmit_flag(xmit_flag), .sda_oe(sda_oe)
);

// File: tb/i2c_addr_status_tb.sv
`timescale 1ns/1ps
module i2c_addr_status_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, is_master = 1'b0;
  logic start_det = 0, stop_det = 0, start_gen = 0, scl_rise = 0, scl_fall = 0;
  logic [7:0] first_byte = 8'h00;
  logic [6:0] own_addr = 7'h2A;
  logic exit_req = 0, wait_cancel = 0, arb_lost = 0;
  logic ext_flag, match_flag, xmit_flag, sda_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_addr_status u_dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic e, input logic m, input logic x, input logic o);
    chk({tag, " ext"}, ext_flag, e);
    chk({tag, " match"}, match_flag, m);
    chk({tag, " xmit"}, xmit_flag, x);
    chk({tag, " sda_oe"}, sda_oe, o);
  endtask

  task automatic rise(); scl_rise = 1; @(negedge clk); scl_rise = 0; endtask
  task automatic fall(); scl_fall = 1; @(negedge clk); scl_fall = 0; endtask
  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin rise(); fall(); end
  endtask
  task automatic sstart(); start_det = 1; @(negedge clk); start_det = 0; endtask

  // start, then eight rises (7 full bits + 8th rise)
  task automatic addr_phase(input logic [7:0] b);
    first_byte = b;
    sstart();
    bits(7);
    rise();
  endtask

  task automatic finish_ack(); fall(); rise(); fall(); endtask

  task automatic t_reset();
    chk_all("R11 reset", 0, 0, 0, 0);
  endtask

  task automatic t_slave_read();
    addr_phase({7'h2A, 1'b1});
    chk_all("R2 R7 slave read 8th edge", 0, 1, 1, 0);
    fall(); rise();
    chk("R8 no drive before 9th fall", sda_oe, 0);
    fall();
    chk("R8 drive after 9th fall", sda_oe, 1);
    first_byte = 8'h01;
    bits(8);
    chk_all("R10 later byte ignored", 0, 1, 1, 1);
    wait_cancel = 1; @(negedge clk); wait_cancel = 0;
    chk_all("R4 wait-cancel", 0, 1, 0, 0);
    stop_det = 1; @(negedge clk); stop_det = 0;
    chk_all("R3 stop", 0, 0, 0, 0);
  endtask

  task automatic t_slave_write_and_miss();
    addr_phase({7'h2A, 1'b0});
    chk_all("R7 slave write", 0, 1, 0, 0);
    finish_ack();
    addr_phase({7'h33, 1'b1});
    chk_all("R5 R2 miss read", 0, 0, 0, 0);
    finish_ack();
  endtask

  task automatic t_ext_codes();
    addr_phase(8'h01);
    chk_all("R1 ext 0000 read", 1, 0, 1, 0);
    finish_ack();
    sstart();
    chk_all("R3 R7 start clears", 0, 0, 0, 0);
    addr_phase(8'hF0);
    chk_all("R1 ext 1111 write", 1, 0, 0, 0);
    finish_ack();
    exit_req = 1; @(negedge clk); exit_req = 0;
    chk("R3 exit clears ext", ext_flag, 0);
  endtask

  task automatic t_exit_enable();
    addr_phase({7'h2A, 1'b1});
    finish_ack();
    exit_req = 1; @(negedge clk); exit_req = 0;
    chk_all("R3 R4 exit", 0, 0, 0, 0);
    addr_phase({7'h2A, 1'b1});
    finish_ack();
    enable = 0; @(negedge clk);
    chk_all("R3 R4 enable fall", 0, 0, 0, 0);
    enable = 1; @(negedge clk);
  endtask

  task automatic t_priority();
    first_byte = {7'h2A, 1'b1};
    sstart();
    bits(7);
    scl_rise = 1; stop_det = 1; @(negedge clk); scl_rise = 0; stop_det = 0;
    chk_all("R9 stop beats 8th edge", 0, 0, 0, 0);
    first_byte = 8'h00;
    sstart();
    bits(7);
    scl_rise = 1; exit_req = 1; @(negedge clk); scl_rise = 0; exit_req = 0;
    chk_all("R9 exit beats 8th edge", 0, 0, 0, 0);
  endtask

  task automatic t_master();
    is_master = 1;
    start_gen = 1; @(negedge clk); start_gen = 0;
    addr_phase({7'h10, 1'b0});
    chk_all("R6 master write", 0, 0, 1, 0);
    finish_ack();
    chk("R8 master drive", sda_oe, 1);
    start_gen = 1; @(negedge clk); start_gen = 0;
    chk_all("R6 start_gen clears", 0, 0, 0, 0);
    addr_phase({7'h10, 1'b0});
    finish_ack();
    arb_lost = 1; @(negedge clk); arb_lost = 0;
    chk("R4 arb lost", xmit_flag, 0);
    start_gen = 1; @(negedge clk); start_gen = 0;
    addr_phase({7'h10, 1'b1});
    chk("R6 master read", xmit_flag, 0);
    finish_ack();
    stop_det = 1; @(negedge clk); stop_det = 0;
    is_master = 0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_slave_read();
    t_slave_write_and_miss();
    t_ext_codes();
    t_exit_enable();
    t_priority();
    t_master();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule